// File: doc/BRIEF.md
# NAND Sector Single-Error Checker

This block takes the parity that was accumulated while a large NAND page streamed in and compares it with the parity that was saved in the page's spare area. The comparison is made separately for each 512-byte sector. For every sector in the requested range it forms a syndrome and sorts the sector into one of three classes: clean, a single flipped bit that can be repaired, or damage that cannot be repaired. When the bit can be repaired, the block reports where it sits in the page: the sector, the byte offset within that sector, and a one-hot mask for the bit inside the byte.

Each parity word holds a 12-bit line code and a 12-bit column code. A single flipped data bit leaves the two halves of the syndrome as exact bitwise complements. When that happens, the upper half gives the address of the bit.

A caller presents the parity words, chooses a sector range and pulses start. The block then looks at one sector per clock, beginning with the lowest sector of the range. It stops at the first sector whose syndrome is not zero. If repair is enabled, it fixes the bad byte in the page buffer through a byte read-modify-write port before it pulses done.

Top module: `nand_ecc_checker`

## Requirements
- R1: Only bits 11:0 and 27:16 of each 32-bit parity word take part in the check. A difference in any other bit between computed and stored parity has no effect on the result.
- R2: When every sector in the range has a zero syndrome (computed XOR stored, masked), the block reports status 2'b00, sector 0, byte 0 and mask 0.
- R3: A nonzero syndrome whose low 12-bit half XOR high 12-bit half is 12'hFFF is reported as status 2'b01. The bit address is high AND NOT low: address bits 11:3 give byte_off_o, and bit_mask_o is 1 shifted left by address bits 2:0.
- R4: Any other nonzero syndrome is reported as status 2'b10, with byte_off_o and bit_mask_o both zero.
- R5: The range select uses these codes: 3'd0 skips the check, 3'd1 selects sectors 0–1, 3'd2 selects sectors 2–3 and 3'd3 selects sectors 0–3. Sectors are examined one per clock from the lowest index upward. Done is first seen 1 + (sectors examined) cycles after the start edge. A skip gives done after 1 cycle with status 2'b00.
- R6: The scan stops at the first sector with a nonzero syndrome and reports that sector's index in err_sect_o. Later sectors are not examined.
- R7: Range codes 3'd4 to 3'd7 pulse range_err_o for one cycle, the cycle after start. They produce no done, and status_o, byte_off_o and bit_mask_o keep their earlier values.
- R8: For a repairable sector with fix_en_i high, the block reads the byte at sector×512 + byte offset and writes back that byte XOR the mask, exactly once, with one cycle of read latency. This adds 2 cycles before done. With fix_en_i low, or for any other outcome, no write occurs.
- R9: A start pulse while a check is in progress is ignored.
- R10: After reset, status_o, done_o, range_err_o, mem_rd_o and mem_wr_o are all zero.
- R11: done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| range_sel_i | input | 3 | Sector range code |
| fix_en_i | input | 1 | Enable repair through the byte port |
| calc_par_i | input | NUM_SECT*32 | Computed parity, sector s in bits s*32+31:s*32 |
| stored_par_i | input | NUM_SECT*32 | Stored parity, same packing |
| status_o | output | 2 | 00 clean, 01 repaired/repairable, 10 uncorrectable |
| err_sect_o | output | SECT_W | Index of the sector that stopped the scan |
| byte_off_o | output | BYTE_W | Byte offset of the bad bit within its sector |
| bit_mask_o | output | 8 | One-hot mask of the bad bit |
| done_o | output | 1 | One-cycle completion pulse |
| range_err_o | output | 1 | One-cycle pulse on an invalid range code |
| mem_rd_o | output | 1 | Byte read request |
| mem_wr_o | output | 1 | Byte write request |
| mem_addr_o | output | PAGE_AW | Byte address within the page |
| mem_wdata_o | output | 8 | Repaired byte |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after mem_rd_o |

## Verification
The bench builds the block with its default parameters: four sectors of 512 bytes, 12-bit fields, and the upper field at bit 16. With these values a 2 KiB page model is small enough to hold in full, so every bit address from byte 0 bit 0 up to byte 511 bit 7 in any sector can be repaired and then checked in memory. Four sectors also allow both half ranges. A fault placed outside the selected half, or behind an earlier faulty sector, can be shown to be ignored.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'b00,
        ECC_FIXED = 2'b01,
        ECC_FATAL = 2'b10
    } ecc_status_e;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_SCAN = 2'd1,
        FSM_RD   = 2'd2,
        FSM_WR   = 2'd3
    } ecc_fsm_e;

    localparam logic [2:0] SEL_SKIP = 3'd0;
    localparam logic [2:0] SEL_LOW  = 3'd1;
    localparam logic [2:0] SEL_HIGH = 3'd2;
    localparam logic [2:0] SEL_ALL  = 3'd3;

endpackage

// File: rtl/ecc_syndrome_unit.sv
module ecc_syndrome_unit #(
    parameter int NUM_SECT = 4,
    parameter int WORD_W   = 32,
    parameter int FIELD_W  = 12,
    parameter int HI_LSB   = 16,
    localparam int SYN_W   = 2 * FIELD_W
) (
    input  logic [NUM_SECT*WORD_W-1:0] calc_i,
    input  logic [NUM_SECT*WORD_W-1:0] stored_i,
    output logic [NUM_SECT*SYN_W-1:0]  syn_o
);

    logic [NUM_SECT*WORD_W-1:0] diff;
    logic                       unused_bits;

    assign diff        = calc_i ^ stored_i;
    assign unused_bits = ^diff;

    // one masked syndrome per sector: {high field, low field}
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        assign syn_o[g*SYN_W +: FIELD_W]           = diff[g*WORD_W +: FIELD_W];
        assign syn_o[g*SYN_W + FIELD_W +: FIELD_W] = diff[g*WORD_W + HI_LSB +: FIELD_W];
    end

endmodule

// File: rtl/ecc_sector_classify.sv
module ecc_sector_classify
    import nand_ecc_pkg::*;
#(
    parameter int FIELD_W = 12,
    localparam int SYN_W  = 2 * FIELD_W
) (
    input  logic [SYN_W-1:0]   syn_i,
    output ecc_status_e        status_o,
    output logic [FIELD_W-1:0] bit_addr_o
);

    logic [FIELD_W-1:0] lo_half;
    logic [FIELD_W-1:0] hi_half;

    assign lo_half = syn_i[FIELD_W-1:0];
    assign hi_half = syn_i[SYN_W-1:FIELD_W];

    always_comb begin
        status_o   = ECC_CLEAN;
        bit_addr_o = '0;
        if (syn_i != '0) begin
            if ((lo_half ^ hi_half) == {FIELD_W{1'b1}}) begin
                status_o   = ECC_FIXED;
                bit_addr_o = hi_half & ~lo_half;
            end else begin
                status_o   = ECC_FATAL;
            end
        end
    end

endmodule

// File: rtl/ecc_range_decode.sv
module ecc_range_decode
    import nand_ecc_pkg::*;
#(
    parameter int NUM_SECT = 4,
    localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
    localparam int HALF    = NUM_SECT / 2
) (
    input  logic [2:0]        sel_i,
    output logic              valid_o,
    output logic              skip_o,
    output logic [SECT_W-1:0] first_o,
    output logic [SECT_W-1:0] last_o
);

    always_comb begin
        valid_o = 1'b1;
        skip_o  = 1'b0;
        first_o = '0;
        last_o  = '0;
        case (sel_i)
            SEL_SKIP: skip_o = 1'b1;
            SEL_LOW: begin
                first_o = '0;
                last_o  = SECT_W'(HALF - 1);
            end
            SEL_HIGH: begin
                first_o = SECT_W'(HALF);
                last_o  = SECT_W'(NUM_SECT - 1);
            end
            SEL_ALL: begin
                first_o = '0;
                last_o  = SECT_W'(NUM_SECT - 1);
            end
            default: valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/nand_ecc_checker.sv
module nand_ecc_checker
    import nand_ecc_pkg::*;
#(
    parameter int NUM_SECT   = 4,
    parameter int SECT_BYTES = 512,
    parameter int WORD_W     = 32,
    parameter int HI_LSB     = 16,
    localparam int FIELD_W   = $clog2(SECT_BYTES * 8),
    localparam int SYN_W     = 2 * FIELD_W,
    localparam int SECT_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
    localparam int BYTE_W    = $clog2(SECT_BYTES),
    localparam int PAGE_AW   = SECT_W + BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [2:0]                 range_sel_i,
    input  logic                       fix_en_i,
    input  logic [NUM_SECT*WORD_W-1:0] calc_par_i,
    input  logic [NUM_SECT*WORD_W-1:0] stored_par_i,
    output logic [1:0]                 status_o,
    output logic [SECT_W-1:0]          err_sect_o,
    output logic [BYTE_W-1:0]          byte_off_o,
    output logic [7:0]                 bit_mask_o,
    output logic                       done_o,
    output logic                       range_err_o,
    output logic                       mem_rd_o,
    output logic                       mem_wr_o,
    output logic [PAGE_AW-1:0]         mem_addr_o,
    output logic [7:0]                 mem_wdata_o,
    input  logic [7:0]                 mem_rdata_i
);

    typedef struct packed {
        ecc_fsm_e                  fsm;
        logic [SECT_W-1:0]         idx;
        logic [SECT_W-1:0]         last;
        logic [NUM_SECT*SYN_W-1:0] syn;
        logic                      fix;
        ecc_status_e               status;
        logic [SECT_W-1:0]         sect;
        logic [BYTE_W-1:0]         byte_off;
        logic [7:0]                mask;
        logic                      done;
        logic                      rerr;
    } chk_state_t;

    chk_state_t st_d, st_q;

    logic [NUM_SECT*SYN_W-1:0] syn_w;
    logic                      rng_valid, rng_skip;
    logic [SECT_W-1:0]         rng_first, rng_last;
    logic [SYN_W-1:0]          cur_syn;
    ecc_status_e               cur_status;
    logic [FIELD_W-1:0]        cur_addr;

    ecc_syndrome_unit #(
        .NUM_SECT(NUM_SECT), .WORD_W(WORD_W), .FIELD_W(FIELD_W), .HI_LSB(HI_LSB)
    ) u_syn (
        .calc_i(calc_par_i), .stored_i(stored_par_i), .syn_o(syn_w)
    );

    ecc_range_decode #(.NUM_SECT(NUM_SECT)) u_rng (
        .sel_i(range_sel_i), .valid_o(rng_valid), .skip_o(rng_skip),
        .first_o(rng_first), .last_o(rng_last)
    );

    assign cur_syn = st_q.syn[st_q.idx*SYN_W +: SYN_W];

    ecc_sector_classify #(.FIELD_W(FIELD_W)) u_cls (
        .syn_i(cur_syn), .status_o(cur_status), .bit_addr_o(cur_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.rerr = 1'b0;
        case (st_q.fsm)
            FSM_IDLE: begin
                if (start_i) begin
                    if (!rng_valid) begin
                        st_d.rerr = 1'b1;
                    end else if (rng_skip) begin
                        st_d.status   = ECC_CLEAN;
                        st_d.sect     = '0;
                        st_d.byte_off = '0;
                        st_d.mask     = '0;
                        st_d.done     = 1'b1;
                    end else begin
                        st_d.fsm  = FSM_SCAN;
                        st_d.idx  = rng_first;
                        st_d.last = rng_last;
                        st_d.syn  = syn_w;
                        st_d.fix  = fix_en_i;
                    end
                end
            end
            FSM_SCAN: begin
                if (cur_status == ECC_CLEAN) begin
                    if (st_q.idx == st_q.last) begin
                        st_d.status   = ECC_CLEAN;
                        st_d.sect     = '0;
                        st_d.byte_off = '0;
                        st_d.mask     = '0;
                        st_d.done     = 1'b1;
                        st_d.fsm      = FSM_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + SECT_W'(1);
                    end
                end else begin
                    st_d.status = cur_status;
                    st_d.sect   = st_q.idx;
                    if (cur_status == ECC_FIXED) begin
                        st_d.byte_off = cur_addr[FIELD_W-1:3];
                        st_d.mask     = 8'(1) << cur_addr[2:0];
                    end else begin
                        st_d.byte_off = '0;
                        st_d.mask     = '0;
                    end
                    if (st_q.fix && cur_status == ECC_FIXED) begin
                        st_d.fsm = FSM_RD;
                    end else begin
                        st_d.done = 1'b1;
                        st_d.fsm  = FSM_IDLE;
                    end
                end
            end
            FSM_RD: st_d.fsm = FSM_WR;
            FSM_WR: begin
                st_d.done = 1'b1;
                st_d.fsm  = FSM_IDLE;
            end
            default: st_d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o    = st_q.status;
    assign err_sect_o  = st_q.sect;
    assign byte_off_o  = st_q.byte_off;
    assign bit_mask_o  = st_q.mask;
    assign done_o      = st_q.done;
    assign range_err_o = st_q.rerr;
    assign mem_rd_o    = (st_q.fsm == FSM_RD);
    assign mem_wr_o    = (st_q.fsm == FSM_WR);
    assign mem_addr_o  = {st_q.sect, st_q.byte_off};
    assign mem_wdata_o = mem_rdata_i ^ st_q.mask;

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_status_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'b11);
    assert_fixed_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'b01) |-> $onehot(bit_mask_o));
    assert_fatal_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'b10) |-> (bit_mask_o == '0 && byte_off_o == '0));
    assert_rerr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |-> (!done_o && $stable(status_o)));
    assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> ($past(mem_rd_o) && $stable(mem_addr_o)));
    assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
    assert_wr_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> done_o);

endmodule

// File: tb/tb_nand_ecc_checker.sv
`timescale 1ns/1ps
module tb_nand_ecc_checker;

    localparam int NS = 4;
    localparam int PAGE = NS * 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] range_sel_i = '0;
    logic fix_en_i = 1'b0;
    logic [NS*32-1:0] calc_par_i = '0;
    logic [NS*32-1:0] stored_par_i = '0;
    logic [1:0] status_o;
    logic [1:0] err_sect_o;
    logic [8:0] byte_off_o;
    logic [7:0] bit_mask_o;
    logic done_o, range_err_o, mem_rd_o, mem_wr_o;
    logic [10:0] mem_addr_o;
    logic [7:0] mem_wdata_o;
    logic [7:0] mem_rdata_i;

    logic [7:0] mem [PAGE];
    logic [31:0] calc_w [NS];
    logic [31:0] stor_w [NS];

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nand_ecc_checker dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .range_sel_i(range_sel_i),
        .fix_en_i(fix_en_i), .calc_par_i(calc_par_i), .stored_par_i(stored_par_i),
        .status_o(status_o), .err_sect_o(err_sect_o), .byte_off_o(byte_off_o),
        .bit_mask_o(bit_mask_o), .done_o(done_o), .range_err_o(range_err_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
        if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
    end

    always @(negedge clk) if (mem_wr_o) wr_cnt++;

    function automatic logic [7:0] init_byte(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    function automatic logic [31:0] single_pat(input logic [11:0] a);
        return {4'h0, a, 4'h0, ~a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected-result model
    logic [1:0] e_status = 2'b00;
    logic [1:0] e_sect   = '0;
    logic [8:0] e_byte   = '0;
    logic [7:0] e_mask   = '0;
    int e_lat;
    bit e_rerr, e_write;

    task automatic model(input logic [2:0] sel, input logic fx);
        int first, last, nev;
        bit stop;
        e_rerr = 1'b0; e_write = 1'b0;
        if (sel > 3'd3) begin
            e_rerr = 1'b1; e_lat = 1;
            return;
        end
        e_status = 2'b00; e_sect = '0; e_byte = '0; e_mask = '0;
        if (sel == 3'd0) begin e_lat = 1; return; end
        first = (sel == 3'd2) ? 2 : 0;
        last  = (sel == 3'd1) ? 1 : 3;
        nev = 0; stop = 1'b0;
        for (int s = first; s <= last && !stop; s++) begin
            logic [31:0] syn;
            logic [11:0] lo, hi, a;
            nev++;
            syn = (calc_w[s] ^ stor_w[s]) & 32'h0FFF0FFF;
            if (syn != 0) begin
                stop = 1'b1;
                lo = syn[11:0]; hi = syn[27:16];
                e_sect = 2'(s);
                if ((lo ^ hi) == 12'hFFF) begin
                    a = hi & ~lo;
                    e_status = 2'b01;
                    e_byte = a[11:3];
                    e_mask = 8'(1) << a[2:0];
                    e_write = fx;
                end else begin
                    e_status = 2'b10;
                end
            end
        end
        e_lat = 1 + nev + (e_write ? 2 : 0);
    endtask

    task automatic run_case(input logic [2:0] sel, input logic fx, input string req);
        int k;
        int addr;
        logic [7:0] orig;
        model(sel, fx);
        addr = int'(e_sect) * 512 + int'(e_byte);
        orig = mem[addr];
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            calc_par_i[s*32 +: 32]   = calc_w[s];
            stored_par_i[s*32 +: 32] = stor_w[s];
        end
        range_sel_i = sel; fix_en_i = fx; start_i = 1'b1;
        wr_cnt = 0;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        while (!done_o && !range_err_o && k < 30) begin
            @(negedge clk);
            k++;
        end
        if (e_rerr) begin
            chk(range_err_o && !done_o, "R7", "range_err pulse", int'(range_err_o), 1);
            chk(status_o == e_status, "R7", "status held", status_o, e_status);
            chk(bit_mask_o == e_mask && byte_off_o == e_byte, "R7", "location held",
                int'(bit_mask_o), int'(e_mask));
            repeat (6) begin
                @(negedge clk);
                chk(!done_o && !range_err_o, "R7", "quiet after invalid", int'(done_o), 0);
            end
            return;
        end
        chk(done_o, req, "done seen", int'(done_o), 1);
        chk(k == e_lat, "R5", "latency", k, e_lat);
        chk(status_o == e_status, req, "status", status_o, e_status);
        chk(err_sect_o == e_sect, "R6", "sector", err_sect_o, e_sect);
        chk(byte_off_o == e_byte, req, "byte offset", byte_off_o, e_byte);
        chk(bit_mask_o == e_mask, req, "bit mask", bit_mask_o, e_mask);
        @(negedge clk);
        chk(!done_o, "R11", "done single pulse", int'(done_o), 0);
        chk(wr_cnt == (e_write ? 1 : 0), "R8", "write count", wr_cnt, e_write ? 1 : 0);
        if (e_write) begin
            chk(mem[addr] == (orig ^ e_mask), "R8", "repaired byte",
                int'(mem[addr]), int'(orig ^ e_mask));
            mem[addr] = orig;
        end
    endtask

    task automatic all_clean();
        for (int s = 0; s < NS; s++) begin
            calc_w[s] = $urandom;
            stor_w[s] = calc_w[s];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < PAGE; i++) mem[i] = init_byte(i);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(status_o == 2'b00 && !done_o && !range_err_o, "R10", "reset outputs",
            int'({status_o, done_o, range_err_o}), 0);
        chk(!mem_rd_o && !mem_wr_o, "R10", "reset mem port", int'({mem_rd_o, mem_wr_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 all clean, whole page
        all_clean();
        run_case(3'd3, 1'b1, "R2");
        // R1 junk outside the fields only
        all_clean();
        for (int s = 0; s < NS; s++) stor_w[s] = calc_w[s] ^ 32'hF000F000;
        run_case(3'd3, 1'b1, "R1");
        // R3 lowest address, sector 0, repaired
        all_clean();
        stor_w[0] = calc_w[0] ^ single_pat(12'h000) ^ 32'hA000_5000;
        run_case(3'd1, 1'b1, "R3");
        // R3 highest address, sector 3
        all_clean();
        stor_w[3] = calc_w[3] ^ single_pat(12'hFFF);
        run_case(3'd3, 1'b1, "R3");
        // R3 repairable but repair disabled
        all_clean();
        stor_w[1] = calc_w[1] ^ single_pat(12'h5A3);
        run_case(3'd3, 1'b0, "R3");
        // R4 double error
        all_clean();
        stor_w[2] = calc_w[2] ^ single_pat(12'h010) ^ single_pat(12'h7C1);
        run_case(3'd2, 1'b1, "R4");
        // R5 fault in sector 0 ignored by upper half range
        all_clean();
        stor_w[0] = calc_w[0] ^ single_pat(12'h123);
        run_case(3'd2, 1'b1, "R5");
        // R6 first bad sector wins
        all_clean();
        stor_w[2] = calc_w[2] ^ single_pat(12'h3C5);
        stor_w[3] = calc_w[3] ^ 32'h0000_0003;
        run_case(3'd2, 1'b1, "R6");
        // R5 skip
        all_clean();
        stor_w[1] = calc_w[1] ^ 32'h0000_0001;
        run_case(3'd0, 1'b1, "R5");
        // R7 invalid after a repairable result
        all_clean();
        stor_w[1] = calc_w[1] ^ single_pat(12'h2B7);
        run_case(3'd3, 1'b0, "R3");
        run_case(3'd5, 1'b1, "R7");
        run_case(3'd7, 1'b0, "R7");

        // R9 start during a scan is ignored
        begin
            int dn;
            all_clean();
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                calc_par_i[s*32 +: 32]   = calc_w[s];
                stored_par_i[s*32 +: 32] = stor_w[s];
            end
            range_sel_i = 3'd3; fix_en_i = 1'b0; start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            @(negedge clk); range_sel_i = 3'd0; start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            dn = 0;
            for (int c = 3; c <= 10; c++) begin
                if (done_o) begin
                    dn++;
                    chk(c == 5, "R9", "done cycle of first run", c, 5);
                end
                @(negedge clk);
            end
            chk(dn == 1, "R9", "done count", dn, 1);
        end

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] sel;
            for (int s = 0; s < NS; s++) begin
                int kind;
                logic [11:0] a, b;
                calc_w[s] = $urandom;
                stor_w[s] = calc_w[s] ^ ($urandom & 32'hF000F000);
                kind = $urandom_range(0, 9);
                a = 12'($urandom);
                b = a ^ 12'($urandom_range(1, 4095));
                if (kind >= 7 && kind <= 8) stor_w[s] ^= single_pat(a);
                else if (kind == 9) stor_w[s] ^= single_pat(a) ^ single_pat(b);
            end
            sel = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(4, 7))
                                              : 3'($urandom_range(0, 3));
            run_case(sel, 1'($urandom), "R3");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule